// File: doc/BRIEF.md
# Power-Down Sequencer with Wake-Up Settling Timer

This block holds an 8-bit control byte that sets how the chip powers down. When the processor executes its sleep operation it raises a one-cycle request. The block then enters one of two power-down modes, chosen by the top bit of the control byte.

In the light mode only the processor is held. Its clocks keep running, and any enabled interrupt releases it with no delay. In the deep mode the block stops the clocks to the processor and the peripheral modules. Only an external interrupt line, or reset, can start the exit. The exit first runs a settling counter so the oscillator can stabilise, and only then releases the hold.

The settling length is a power-of-two multiple of a base count, picked by a 3-bit field of the control byte. Field codes above 4 are stored as written, but they time out as code 4. The base count is a parameter whose default is 8192 states, so the default lengths run from 8192 to 131072 states.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the control byte reads 0x09, the mode status is 00 (running), and both cpu_hold and clk_stop are low.
- R2: Bit 3 of the control byte is a read-only flag with reset value 1. A write leaves it unchanged.
- R3: A write stores bits 7..4 and 2..0 of the written byte, so the byte read back equals (wdata & 0xF7) | 0x08.
- R4: A sleep request while running with bit 7 = 0 gives mode 01 (light sleep) on the next clock, with cpu_hold high and clk_stop low. Bit 7 is taken as it stands before any write in the same cycle.
- R5: A sleep request while running with bit 7 = 1 gives mode 10 (deep standby) on the next clock, with cpu_hold and clk_stop both high.
- R6: In mode 01, any_irq drops cpu_hold in the same cycle, and the mode returns to 00 on the next clock.
- R7: In mode 10, any_irq has no effect. Any bit of ext_irq moves the mode to 11 (settling) on the next clock.
- R8: For field code c in bits 6..4 with c ≤ 4, mode 11 lasts SETTLE_BASE·2^c cycles. cpu_hold and clk_stop stay high in every one of those cycles except the last.
- R9: Codes 5, 6 and 7 read back as written. They give a settling length of SETTLE_BASE·16 cycles.
- R10: In the last settling cycle, cpu_hold and clk_stop fall in that same cycle, and the mode is 00 on the next clock.
- R11: Bit 7 stays 1 after a wake from deep standby. It clears only through a write.
- R12: Asserting rst_n low in any mode returns the mode to 00 at once, lowers both outputs and reloads 0x09.
- R13: A sleep request outside mode 00 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control byte |
| sleep_req | input | 1 | One-cycle sleep request from the processor |
| ext_irq | input | NUM_EXT | External interrupt lines that can wake from deep standby |
| any_irq | input | 1 | Any enabled interrupt, wakes from light sleep |
| clk_stop | output | 1 | Gates processor and peripheral clocks |
| cpu_hold | output | 1 | Holds the processor and peripherals |
| pd_mode | output | 2 | 00 running, 01 light sleep, 10 deep standby, 11 settling |

## Verification
The bench covers two same-cycle coincidences.

The first is a register write that lands in the cycle of a sleep request. The bench raises the standby-select bit in that very cycle. It expects light sleep, because the mode decision must use the old byte, while the new byte must still be stored.

The second is an interrupt arriving in a mode that must ignore it. The bench pulses any_irq during deep standby and expects no change. It then checks the exit against a settling length computed from the field code, counting both the held cycles and the single release cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_NAP    = 2'b01,
    MODE_DEEP   = 2'b10,
    MODE_SETTLE = 2'b11
  } pd_mode_e;

  localparam logic [7:0] CTRL_RESET = 8'h09;
  localparam logic [2:0] SEL_TOP    = 3'd4;

  // Codes above the top legal selection time out as the top selection.
  function automatic logic [2:0] settle_shift(input logic [2:0] code);
    return (code > SEL_TOP) ? SEL_TOP : code;
  endfunction

  function automatic int unsigned settle_cycles(input int unsigned base,
                                                input logic [2:0] code);
    return base << settle_shift(code);
  endfunction

endpackage

// File: rtl/stby_ctrl_reg.sv
module stby_ctrl_reg
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       deep_sel,
  output logic [2:0] settle_code
);

  logic [7:0] ctrl_q;

  // Bit 3 has no write path: it keeps its reset value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else if (we) ctrl_q <= {wdata[7:4], ctrl_q[3], wdata[2:0]};
  end

  assign rdata       = ctrl_q;
  assign deep_sel    = ctrl_q[7];
  assign settle_code = ctrl_q[6:4];

endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt
  import stby_pkg::*;
#(
  parameter int unsigned SETTLE_BASE = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [2:0] code,
  output logic       done
);

  localparam int CW = $clog2(SETTLE_BASE * 16) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;

  // The length is taken from the code at the moment the count starts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (start) begin
      cnt_q  <= '0;
      last_q <= CW'(settle_cycles(SETTLE_BASE, code) - 1);
    end else if (run && !done) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done = run && (cnt_q == last_q);

endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       any_irq,
  input  logic       ext_hit,
  input  logic       deep_sel,
  input  logic       settle_done,
  output pd_mode_e   mode,
  output logic       settle_start,
  output logic       settle_run,
  output logic       hold,
  output logic       clk_stop
);

  pd_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:    if (sleep_req)   mode_d = deep_sel ? MODE_DEEP : MODE_NAP;
      MODE_NAP:    if (any_irq)     mode_d = MODE_RUN;
      MODE_DEEP:   if (ext_hit)     mode_d = MODE_SETTLE;
      MODE_SETTLE: if (settle_done) mode_d = MODE_RUN;
      default:                      mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end

  assign mode         = mode_q;
  assign settle_start = (mode_q == MODE_DEEP) && ext_hit;
  assign settle_run   = (mode_q == MODE_SETTLE);
  assign hold         = ((mode_q == MODE_NAP) && !any_irq) ||
                        (mode_q == MODE_DEEP) ||
                        ((mode_q == MODE_SETTLE) && !settle_done);
  assign clk_stop     = (mode_q == MODE_DEEP) ||
                        ((mode_q == MODE_SETTLE) && !settle_done);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned NUM_EXT     = 2,
  parameter int unsigned SETTLE_BASE = 8192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               sleep_req,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic               any_irq,
  output logic               clk_stop,
  output logic               cpu_hold,
  output logic [1:0]         pd_mode
);

  logic       deep_sel;
  logic [2:0] settle_code;
  logic       ext_hit;
  logic       settle_start;
  logic       settle_run;
  logic       settle_done;
  pd_mode_e   mode;

  assign ext_hit = |ext_irq;
  assign pd_mode = mode;

  stby_ctrl_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (reg_we),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .deep_sel    (deep_sel),
    .settle_code (settle_code)
  );

  stby_settle_cnt #(.SETTLE_BASE(SETTLE_BASE)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .run   (settle_run),
    .code  (settle_code),
    .done  (settle_done)
  );

  stby_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .any_irq      (any_irq),
    .ext_hit      (ext_hit),
    .deep_sel     (deep_sel),
    .settle_done  (settle_done),
    .mode         (mode),
    .settle_start (settle_start),
    .settle_run   (settle_run),
    .hold         (cpu_hold),
    .clk_stop     (clk_stop)
  );

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_rdata,
  input logic       sleep_req,
  input logic       any_irq,
  input logic       ext_hit,
  input logic       settle_done,
  input logic       clk_stop,
  input logic       cpu_hold,
  input logic [1:0] pd_mode
);

  AST_NAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'b00 && sleep_req && !reg_rdata[7]) |=> (pd_mode == 2'b01)); // R4

  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'b00 && sleep_req && reg_rdata[7]) |=> (pd_mode == 2'b10 && clk_stop)); // R5

  AST_NAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'b01 && any_irq) |-> !cpu_hold); // R6

  AST_NAP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'b01 && any_irq) |=> (pd_mode == 2'b00)); // R6

  AST_DEEP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'b10 && !ext_hit) |=> (pd_mode == 2'b10)); // R7

  AST_SETTLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'b11 && !settle_done) |-> (cpu_hold && clk_stop)); // R8

  AST_EXPIRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |-> (!cpu_hold && !clk_stop)); // R10

  AST_EXPIRY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |=> (pd_mode == 2'b00)); // R10

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[7]) |-> $past(reg_we)); // R11

  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode == 2'b10 && sleep_req && !ext_hit) |=> (pd_mode == 2'b10)); // R13

endmodule

bind stby_ctrl stby_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_rdata   (reg_rdata),
  .sleep_req   (sleep_req),
  .any_irq     (any_irq),
  .ext_hit     (ext_hit),
  .settle_done (settle_done),
  .clk_stop    (clk_stop),
  .cpu_hold    (cpu_hold),
  .pd_mode     (pd_mode)
);

// File: tb/sim_stby_ctrl.sv
module sim_stby_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NEXT       = 2;
  localparam int BASE       = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            reg_we;
  logic [7:0]      reg_wdata;
  logic [7:0]      reg_rdata;
  logic            sleep_req;
  logic [NEXT-1:0] ext_irq;
  logic            any_irq;
  logic            clk_stop;
  logic            cpu_hold;
  logic [1:0]      pd_mode;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_ctrl #(.NUM_EXT(NEXT), .SETTLE_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_req(sleep_req), .ext_irq(ext_irq),
    .any_irq(any_irq), .clk_stop(clk_stop), .cpu_hold(cpu_hold),
    .pd_mode(pd_mode)
  );

  // Bench's own view of the stored byte and the settling length.
  function automatic logic [7:0] exp_byte(input logic [7:0] w);
    return {w[7:4], 1'b1, w[2:0]};
  endfunction

  function automatic int exp_len(input logic [2:0] c);
    case (c)
      3'd0: return BASE;
      3'd1: return BASE * 2;
      3'd2: return BASE * 4;
      3'd3: return BASE * 8;
      default: return BASE * 16;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] w);
    reg_we = 1'b1; reg_wdata = w;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  // Enter deep standby with the given code, wake, measure the settle.
  task automatic deep_cycle(input logic [2:0] code);
    int n;
    int held;
    logic rel_ok;
    write_byte({1'b1, code, 4'b0001});
    check("R9 code readback", reg_rdata[6:4], code);
    pulse_sleep();
    check("R5 deep mode", pd_mode, 2);
    check("R5 clk_stop", clk_stop, 1);
    check("R5 hold", cpu_hold, 1);
    any_irq = 1'b1;
    tick();
    any_irq = 1'b0;
    check("R7 any_irq ignored", pd_mode, 2);
    ext_irq = NEXT'(1) << ($urandom % NEXT);
    tick();
    ext_irq = '0;
    check("R7 settle start", pd_mode, 3);
    n = 0; held = 0; rel_ok = 1'b0;
    while (pd_mode == 2'b11 && n < 1000) begin
      if (cpu_hold && clk_stop) held++;
      else rel_ok = !cpu_hold && !clk_stop;
      n++;
      tick();
    end
    check(code > 4 ? "R9 settle length" : "R8 settle length", n, exp_len(code));
    check("R8 held cycles", held, exp_len(code) - 1);
    check("R10 release in last cycle", rel_ok, 1);
    check("R10 running after", pd_mode, 0);
    check("R11 select bit kept", reg_rdata[7], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; sleep_req = 1'b0;
    ext_irq = '0; any_irq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset byte", reg_rdata, 8'h09);
    check("R1 reset mode", pd_mode, 0);
    check("R1 reset hold", cpu_hold, 0);
    check("R1 reset clk_stop", clk_stop, 0);
    rst_n = 1'b1;
    tick();

    write_byte(8'h00);
    check("R2 flag read-only", reg_rdata, 8'h08);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      write_byte(w);
      check("R3 write readback", reg_rdata, exp_byte(w));
    end

    // Light sleep, with a same-cycle write raising the select bit.
    write_byte(8'h00);
    reg_we = 1'b1; reg_wdata = 8'h80; sleep_req = 1'b1;
    tick();
    reg_we = 1'b0; sleep_req = 1'b0;
    check("R4 old select used", pd_mode, 1);
    check("R3 same-cycle write stored", reg_rdata, 8'h88);
    check("R4 hold", cpu_hold, 1);
    check("R4 clk_stop low", clk_stop, 0);
    pulse_sleep();
    check("R13 request ignored in sleep", pd_mode, 1);
    any_irq = 1'b1;
    #1;
    check("R6 hold drops same cycle", cpu_hold, 0);
    @(negedge clk);
    any_irq = 1'b0;
    check("R6 running next", pd_mode, 0);

    // Deep standby over every code, then random codes.
    for (int c = 0; c < 8; c++) deep_cycle(3'(c));
    for (int i = 0; i < 6; i++) deep_cycle(3'($urandom));
    write_byte(8'h21);
    check("R11 cleared by write", reg_rdata[7], 0);

    // Reset mid-settle.
    write_byte(8'hC1);
    pulse_sleep();
    ext_irq = 1;
    tick();
    ext_irq = '0;
    tick();
    rst_n = 1'b0;
    #1;
    check("R12 mode after reset", pd_mode, 0);
    check("R12 hold after reset", cpu_hold, 0);
    check("R12 clk_stop after reset", clk_stop, 0);
    check("R12 byte after reset", reg_rdata, 8'h09);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    // Reset during light sleep.
    pulse_sleep();
    check("R4 sleep entered", pd_mode, 1);
    rst_n = 1'b0;
    #1;
    check("R12 reset from sleep", pd_mode, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule